// File: doc/BRIEF.md
# Secondary Interrupt Controller with Passthrough

This block gathers 32 level-sensitive interrupt sources and presents them to a primary vectored interrupt controller. Each bus clock the source levels are captured into a raw-level register. A per-source enable mask selects which captured levels feed one combined request, driven on primary line 31. Sources 21 to 30 can also be forwarded one-to-one onto their own primary lines. This forwarding is switched per line by a separate passthrough-enable register.

Software reaches the block through an APB-style 32-bit slave with a 4 KB window. Registers are decoded on the word index (byte address shifted right by two). The bus side is a two-state machine. In `BUS_IDLE` a setup phase (select high, enable low) causes the transition `IDLE->ACCESS`, and read data is captured on that edge. In `BUS_ACCESS` the access phase (select and enable high) performs any write and takes the transition `ACCESS->IDLE`. Dropping select in `BUS_ACCESS` also returns to `BUS_IDLE`. The slave never inserts wait states and never reports an error.

Top module: `sic_passthru`

## Requirements
- R1: After reset the raw-level, enable-mask and passthrough-enable registers are zero, all 32 `prim_irq` lines are low, and `prdata` is zero.
- R2: Reading word index 1 returns the raw source levels. Index 0 returns raw levels AND enable mask. Index 2 returns the enable mask.
- R3: Writing index 2 ORs the write data into the enable mask. Writing index 3 clears every mask bit where the write data has a 1.
- R4: `src_in` is captured into the raw-level register on each rising edge. `prim_irq[31]` is registered and equals the OR of (raw level AND mask) as it stood one edge earlier.
- R5: Writing index 8 sets passthrough-enable bits using only bits 21..30 of the write data (mask 0x7FE00000), ignoring all other bits. Reading index 8 returns the passthrough-enable register.
- R6: Writing index 9 clears the passthrough-enable bits where the write data has a 1. The affected line goes low on the edge after the write.
- R7: For i in 21..30, `prim_irq[i]` is registered and equals raw level i AND passthrough-enable i, one edge later. Lines 0..20 are always low.
- R8: Reading index 4 returns raw level bit 0 in bit 0, with all other bits zero. A nonzero write to index 4 sets mask bit 0, and a nonzero write to index 5 clears it. A zero write to either leaves the mask unchanged.
- R9: Any word index other than 0, 1, 2, 4 or 8 reads as zero. Writes to any index other than 2, 3, 4, 5, 8 or 9 change no register.
- R10: `pready` is always high and `pslverr` always low, so every transfer completes in its first access cycle.
- R11: A register write and a source change that occur on the same edge both take effect together. The summary output on the next edge reflects the new mask and the new level, with no intermediate pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer complete (tied high) |
| pslverr | output | 1 | Error response (tied low) |
| src_in | input | 32 | Interrupt source levels, already synchronous to `clk` |
| prim_irq | output | 32 | Lines to the primary controller |

## Verification
The two functions that can land on the same edge are a mask write completing its access phase and a source level changing. The bench provokes this by raising a source in the very cycle that the enable-clear of that source is in its access phase. The summary must then stay low on every sampled cycle. The mirror case raises a source while enabling it in the same access; here the summary must stay low one cycle and be high on the next, never earlier or later.

// File: rtl/sic_pkg.sv
package sic_pkg;

    // Bus-side state machine states.
    typedef enum logic {
        BUS_IDLE   = 1'b0,
        BUS_ACCESS = 1'b1
    } bus_state_e;

    // Low four bits of the word index; upper bits must be zero for a hit.
    typedef enum logic [3:0] {
        SEL_STATUS  = 4'd0,
        SEL_RAW     = 4'd1,
        SEL_EN_SET  = 4'd2,
        SEL_EN_CLR  = 4'd3,
        SEL_SOFT    = 4'd4,
        SEL_SOFTCLR = 4'd5,
        SEL_PT_SET  = 4'd8,
        SEL_PT_CLR  = 4'd9
    } reg_sel_e;

    localparam int SEL_W = 4;

    // Build a contiguous mask of bits lo..hi.
    function automatic logic [31:0] range_mask(input int lo, input int hi);
        logic [31:0] m;
        m = '0;
        for (int b = 0; b < 32; b++) begin
            if (b >= lo && b <= hi) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sic_bus_fsm.sv
module sic_bus_fsm
    import sic_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] rd_value,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] prdata,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);

    bus_state_e state_q, state_d;
    logic       setup_seen;
    logic       access_seen;

    assign setup_seen  = psel && !penable;
    assign access_seen = psel && penable;
    assign rd_idx      = paddr[ADDR_W-1:2];

    // Next-state logic: IDLE->ACCESS on setup, ACCESS->IDLE on access or abort.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:   if (setup_seen) state_d = BUS_ACCESS;
            BUS_ACCESS: state_d = BUS_IDLE;
            default:    state_d = BUS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // Outputs: write strobe in access phase, read data captured at setup.
    always_comb begin
        wr_en   = (state_q == BUS_ACCESS) && access_seen && pwrite;
        wr_idx  = paddr[ADDR_W-1:2];
        wr_data = pwdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prdata <= '0;
        end else if (state_q == BUS_IDLE && setup_seen && !pwrite) begin
            prdata <= rd_value;
        end
    end

endmodule

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int          NSRC    = 32,
    parameter int          IDX_W   = 10,
    parameter logic [31:0] PT_MASK = 32'h7FE0_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_in,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [NSRC-1:0]  wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [NSRC-1:0]  rd_value,
    output logic [NSRC-1:0]  level_o,
    output logic [NSRC-1:0]  mask_o,
    output logic [NSRC-1:0]  pten_o
);

    localparam logic [NSRC-1:0] PT_KEEP = PT_MASK[NSRC-1:0];

    logic [NSRC-1:0] level_q, mask_q, pten_q;
    logic [NSRC-1:0] mask_d, pten_d;
    logic            wr_hit, rd_hit;
    reg_sel_e        wr_sel, rd_sel;
    logic            wr_any;

    assign wr_hit = (wr_idx[IDX_W-1:SEL_W] == '0);
    assign rd_hit = (rd_idx[IDX_W-1:SEL_W] == '0);
    assign wr_sel = reg_sel_e'(wr_idx[SEL_W-1:0]);
    assign rd_sel = reg_sel_e'(rd_idx[SEL_W-1:0]);
    assign wr_any = |wr_data;

    // Register update decode.
    always_comb begin
        mask_d = mask_q;
        pten_d = pten_q;
        if (wr_en && wr_hit) begin
            case (wr_sel)
                SEL_EN_SET:  mask_d = mask_q | wr_data;
                SEL_EN_CLR:  mask_d = mask_q & ~wr_data;
                SEL_SOFT:    if (wr_any) mask_d[0] = 1'b1;
                SEL_SOFTCLR: if (wr_any) mask_d[0] = 1'b0;
                SEL_PT_SET:  pten_d = pten_q | (wr_data & PT_KEEP);
                SEL_PT_CLR:  pten_d = pten_q & ~wr_data;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            mask_q  <= '0;
            pten_q  <= '0;
        end else begin
            level_q <= src_in;
            mask_q  <= mask_d;
            pten_q  <= pten_d;
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_value = '0;
        if (rd_hit) begin
            case (rd_sel)
                SEL_STATUS: rd_value = level_q & mask_q;
                SEL_RAW:    rd_value = level_q;
                SEL_EN_SET: rd_value = mask_q;
                SEL_SOFT:   rd_value[0] = level_q[0];
                SEL_PT_SET: rd_value = pten_q;
                default:    rd_value = '0;
            endcase
        end
    end

    assign level_o = level_q;
    assign mask_o  = mask_q;
    assign pten_o  = pten_q;

endmodule

// File: rtl/sic_outs.sv
module sic_outs #(
    parameter int NSRC     = 32,
    parameter int PT_LO    = 21,
    parameter int PT_HI    = 30,
    parameter int SUM_LINE = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] level,
    input  logic [NSRC-1:0] mask,
    input  logic [NSRC-1:0] pten,
    output logic [NSRC-1:0] prim_irq
);

    logic summary;
    assign summary = |(level & mask);

    for (genvar i = 0; i < NSRC; i++) begin : g_line
        if (i == SUM_LINE) begin : g_sum
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prim_irq[i] <= 1'b0;
                else        prim_irq[i] <= summary;
            end
        end else if (i >= PT_LO && i <= PT_HI) begin : g_pt
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prim_irq[i] <= 1'b0;
                else        prim_irq[i] <= level[i] & pten[i];
            end
        end else begin : g_off
            assign prim_irq[i] = 1'b0;
        end
    end

endmodule

// File: rtl/sic_passthru.sv
module sic_passthru
    import sic_pkg::*;
#(
    parameter int NSRC     = 32,
    parameter int ADDR_W   = 12,
    parameter int PT_LO    = 21,
    parameter int PT_HI    = 30,
    parameter int SUM_LINE = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [NSRC-1:0]   pwdata,
    output logic [NSRC-1:0]   prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [NSRC-1:0]   src_in,
    output logic [NSRC-1:0]   prim_irq
);

    localparam int          IDX_W   = ADDR_W - 2;
    localparam logic [31:0] PT_MASK = range_mask(PT_LO, PT_HI);

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [NSRC-1:0]  rd_value, wr_data;
    logic             wr_en;
    logic [NSRC-1:0]  level_w, mask_w, pten_w;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    sic_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(NSRC)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .rd_value (rd_value),
        .rd_idx   (rd_idx),
        .prdata   (prdata),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    sic_regs #(.NSRC(NSRC), .IDX_W(IDX_W), .PT_MASK(PT_MASK)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_value (rd_value),
        .level_o  (level_w),
        .mask_o   (mask_w),
        .pten_o   (pten_w)
    );

    sic_outs #(.NSRC(NSRC), .PT_LO(PT_LO), .PT_HI(PT_HI), .SUM_LINE(SUM_LINE)) u_outs (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level_w),
        .mask     (mask_w),
        .pten     (pten_w),
        .prim_irq (prim_irq)
    );

endmodule

// File: rtl/sic_passthru_chk.sv
module sic_passthru_chk #(
    parameter int NSRC     = 32,
    parameter int IDX_W    = 10,
    parameter int PT_LO    = 21,
    parameter int PT_HI    = 30,
    parameter int SUM_LINE = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  src_in,
    input logic [NSRC-1:0]  prim_irq,
    input logic             pready,
    input logic             pslverr,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [NSRC-1:0]  wr_data,
    input logic [NSRC-1:0]  lvl,
    input logic [NSRC-1:0]  msk,
    input logic [NSRC-1:0]  pten
);

    logic [NSRC-1:0] out_range;
    logic            mapped_wr;

    always_comb begin
        out_range = '1;
        for (int b = PT_LO; b <= PT_HI; b++) out_range[b] = 1'b0;
        mapped_wr = (wr_idx == 2) || (wr_idx == 3) || (wr_idx == 4) ||
                    (wr_idx == 5) || (wr_idx == 8) || (wr_idx == 9);
    end

    AST_LEVEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lvl == $past(src_in)); // R4
    AST_SUMMARY_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> prim_irq[SUM_LINE] == $past(|(lvl & msk))); // R4
    AST_ENSET_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 2) |=> msk == ($past(msk) | $past(wr_data))); // R3
    AST_ENCLR_AND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 3) |=> msk == ($past(msk) & ~$past(wr_data))); // R3
    AST_PT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pten & out_range) == '0); // R5
    AST_PT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> prim_irq[PT_HI:PT_LO] == $past(lvl[PT_HI:PT_LO] & pten[PT_HI:PT_LO])); // R7
    AST_PT_CLEAR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 9 && wr_data[PT_LO]) |=> ##1 !prim_irq[PT_LO]); // R6
    AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mapped_wr) |=> $stable(msk) && $stable(pten)); // R9
    AST_BUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr); // R10

endmodule

bind sic_passthru sic_passthru_chk #(
    .NSRC(NSRC), .IDX_W(ADDR_W - 2), .PT_LO(PT_LO), .PT_HI(PT_HI), .SUM_LINE(SUM_LINE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_in   (src_in),
    .prim_irq (prim_irq),
    .pready   (pready),
    .pslverr  (pslverr),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .lvl      (level_w),
    .msk      (mask_w),
    .pten     (pten_w)
);

// File: tb/sic_passthru_test.sv
`timescale 1ns/1ps
module sic_passthru_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [31:0] src_in = '0;
    logic [31:0] prim_irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    sic_passthru uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .src_in(src_in), .prim_irq(prim_irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic apb_wr(input int idx, input logic [31:0] data);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1;
        paddr = 12'(idx << 2); pwdata = data;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input int idx, output logic [31:0] data);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 12'(idx << 2);
        @(negedge clk);
        penable = 1'b1;
        data = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic settle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 prim_irq after reset", prim_irq, 32'h0);
        check("R1 prdata after reset", prdata, 32'h0);
        apb_rd(1, d); check("R1 raw level zero", d, 32'h0);
        apb_rd(2, d); check("R1 mask zero", d, 32'h0);
        apb_rd(8, d); check("R1 passthrough zero", d, 32'h0);
    endtask

    task automatic t_enable_rw();
        logic [31:0] d;
        apb_wr(2, 32'h0000_00F0);
        apb_wr(2, 32'h0001_0000);
        apb_rd(2, d); check("R3 enable set ORs", d, 32'h0001_00F0);
        apb_wr(3, 32'h0000_0030);
        apb_rd(2, d); check("R3 enable clear", d, 32'h0001_00C0);
        apb_wr(3, 32'hFFFF_FFFF);
        apb_rd(2, d); check("R3 enable clear all", d, 32'h0);
    endtask

    task automatic t_summary();
        logic [31:0] d;
        @(negedge clk); src_in[3] = 1'b1;
        settle(2);
        check("R4 summary low with mask clear", 32'(prim_irq[31]), 32'h0);
        apb_rd(1, d); check("R2 raw shows source 3", d, 32'h0000_0008);
        apb_rd(0, d); check("R2 status masked off", d, 32'h0);
        apb_wr(2, 32'h0000_0008);
        settle(1);
        check("R4 summary high after enable", 32'(prim_irq[31]), 32'h1);
        apb_rd(0, d); check("R2 status shows source 3", d, 32'h0000_0008);
        @(negedge clk); src_in[3] = 1'b0;
        settle(1);
        check("R4 summary holds one edge", 32'(prim_irq[31]), 32'h1);
        settle(1);
        check("R4 summary drops after source", 32'(prim_irq[31]), 32'h0);
        apb_wr(3, 32'h0000_0008);
    endtask

    task automatic t_soft();
        logic [31:0] d;
        @(negedge clk); src_in[0] = 1'b1; src_in[1] = 1'b1;
        settle(1);
        apb_rd(4, d); check("R8 soft read is level bit 0 only", d, 32'h1);
        apb_wr(4, 32'h0);
        apb_rd(2, d); check("R8 zero write to set ignored", d, 32'h0);
        apb_wr(4, 32'h0000_0080);
        apb_rd(2, d); check("R8 nonzero write sets mask bit 0", d, 32'h1);
        check("R8 summary from soft bit", 32'(prim_irq[31]), 32'h1);
        apb_wr(5, 32'h0);
        apb_rd(2, d); check("R8 zero write to clear ignored", d, 32'h1);
        apb_wr(5, 32'h4000_0000);
        apb_rd(2, d); check("R8 nonzero write clears mask bit 0", d, 32'h0);
        @(negedge clk); src_in[0] = 1'b0; src_in[1] = 1'b0;
        settle(2);
    endtask

    task automatic t_passthrough();
        logic [31:0] d;
        @(negedge clk); src_in[22] = 1'b1; src_in[25] = 1'b1; src_in[10] = 1'b1;
        settle(2);
        check("R7 no passthrough before enable", prim_irq, 32'h0);
        apb_wr(8, 32'hFFFF_FFFF);
        apb_rd(8, d); check("R5 set limited to bits 21..30", d, 32'h7FE0_0000);
        check("R7 lines 22 and 25 follow level", prim_irq, 32'h0240_0000);
        @(negedge clk); src_in[22] = 1'b0; src_in[23] = 1'b1;
        settle(2);
        check("R7 lines track new levels", prim_irq, 32'h0280_0000);
        apb_wr(9, 32'h0200_0000);
        apb_rd(8, d); check("R6 clear drops bit 25", d, 32'h7DE0_0000);
        check("R6 line 25 low after clear", prim_irq, 32'h0080_0000);
        apb_wr(9, 32'hFFFF_FFFF);
        settle(1);
        check("R6 all passthrough lines low", prim_irq, 32'h0);
        @(negedge clk); src_in = '0;
        settle(2);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        apb_wr(2, 32'h0000_1000);
        apb_wr(8, 32'h0040_0000);
        apb_wr(0, 32'hFFFF_FFFF);
        apb_wr(1, 32'hFFFF_FFFF);
        apb_wr(6, 32'hFFFF_FFFF);
        apb_wr(10, 32'hFFFF_FFFF);
        apb_wr(1023, 32'hFFFF_FFFF);
        apb_rd(2, d); check("R9 mask untouched by other indices", d, 32'h0000_1000);
        apb_rd(8, d); check("R9 passthrough untouched", d, 32'h0040_0000);
        apb_rd(3, d); check("R9 index 3 reads zero", d, 32'h0);
        apb_rd(9, d); check("R9 index 9 reads zero", d, 32'h0);
        apb_rd(7, d); check("R9 index 7 reads zero", d, 32'h0);
        apb_rd(20, d); check("R9 index 20 reads zero", d, 32'h0);
        apb_wr(3, 32'hFFFF_FFFF);
        apb_wr(9, 32'hFFFF_FFFF);
    endtask

    task automatic t_same_cycle();
        apb_wr(2, 32'h0000_0020);
        settle(1);
        // Clear of source 5 completes on the edge its level rises.
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'(3 << 2); pwdata = 32'h20;
        @(negedge clk);
        penable = 1'b1; src_in[5] = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        check("R11 no pulse on clear plus rise (1)", 32'(prim_irq[31]), 32'h0);
        settle(1);
        check("R11 no pulse on clear plus rise (2)", 32'(prim_irq[31]), 32'h0);
        // Enable of source 6 completes on the edge its level rises.
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'(2 << 2); pwdata = 32'h40;
        @(negedge clk);
        penable = 1'b1; src_in[6] = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        check("R11 summary not early", 32'(prim_irq[31]), 32'h0);
        settle(1);
        check("R11 summary on next edge", 32'(prim_irq[31]), 32'h1);
        @(negedge clk); src_in = '0;
        apb_wr(3, 32'hFFFF_FFFF);
    endtask

    task automatic t_bus_resp();
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = '0;
        @(negedge clk);
        penable = 1'b1;
        check("R10 pready in first access cycle", 32'(pready), 32'h1);
        check("R10 pslverr low", 32'(pslverr), 32'h0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);
        t_reset();
        t_enable_rw();
        t_summary();
        t_soft();
        t_passthrough();
        t_unmapped();
        t_same_cycle();
        t_bus_resp();
        settle(2);
        finish_run();
    end

endmodule